// File: doc/BRIEF.md
# SDRAM Initialisation and Timing-Select Controller

This block sits between a simple memory-access requester and an SDRAM device. A single configuration register holds five one-bit timing selections: CAS latency, row-to-column delay, write recovery, precharge time and the row-cycle gap that follows a mode-register load. Each bit picks one of two fixed values. At the clock period given by a parameter, each nanosecond budget becomes a whole number of cycles, rounded up. The same register carries a memory-size code and two self-clearing control bits.

Software brings the device up in three steps. It sets the start-init bit, and the controller issues a precharge-all command. The bit reads back as 1 until the precharge time has passed, then clears by itself. Next, software sets the mode-arm bit. The next access is then turned into a Load Mode Register command whose mode value is the access address with its two low bits dropped, since the data bus is 32 bits wide. The controller holds any such mode load until a settle window (200 µs by default) has passed since initialisation finished.

In normal operation each access is a complete ACTIVE, READ or WRITE, then PRECHARGE sequence. The requester receives a one-cycle acknowledge.

Top module: `sdcfg_ctrl`

## Requirements
- R1: After reset the register reads 0, the command output is NOP (0), the acknowledge is low and the size output reads 4.
- R2: Register bits: [0] CAS latency 3, [1] slow row-to-column, [2] slow write recovery, [3] slow precharge, [4] slow mode-load gap, [5] mode-arm, [6] start-init, [10:8] size code. Timing and size bits read back as written. Writing 0 to bit 5 or bit 6 has no effect.
- R3: The acknowledge is a single cycle, asserted 2 cycles (bit 0 clear) or 3 cycles (bit 0 set) after the READ or WRITE command.
- R4: The READ or WRITE command follows ACTIVE by ceil(25 ns / period) cycles, or ceil(50 ns / period) when bit 1 is set. At 20 ns this is 2 or 3.
- R5: After a write, the bank PRECHARGE comes ceil(25 or 50 ns / period) cycles after the acknowledge, chosen by bit 2. After a read, it comes in the cycle after the acknowledge.
- R6: After PRECHARGE or precharge-all, no command is issued for ceil(25 or 50 ns / period) cycles, chosen by bit 3. A waiting access gets its ACTIVE one cycle after that window.
- R7: Writing 1 to bit 6 issues a precharge-all (address bit 10 high) one cycle after the bit becomes visible. The bit reads 1 until the precharge window ends. Accesses are stalled meanwhile, and a waiting one gets ACTIVE in the cycle after the bit clears.
- R8: A mode-load access is held until ceil(SETTLE_NS / period) cycles after initialisation clears. It is issued one cycle after that window.
- R9: With bit 5 set, the next access is issued as LMR (command 6) with address = access address [14:2]. It is acknowledged ceil(75 or 100 ns / period) cycles later, chosen by bit 4. Bit 5 then clears, and later accesses are normal.
- R10: The size output equals 4 shifted left by the size code (code 1 gives 8, code 5 gives 128).
- R11: Command codes: NOP 0, ACTIVE 1, READ 2, WRITE 3, PRECHARGE 4, precharge-all 5, LMR 6. ACTIVE carries access address [23:11]. READ and WRITE carry [10:2], zero-extended. PRECHARGE drives address 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_wdata | input | 16 | Register write data |
| cfg_rdata | output | 16 | Register read value |
| acc_req | input | 1 | Access request, held until acknowledge |
| acc_we | input | 1 | Access is a write |
| acc_addr | input | AW (24) | Access byte address |
| acc_ack | output | 1 | One-cycle access acknowledge |
| sd_cmd | output | 3 | SDRAM command code |
| sd_addr | output | SDA_W (13) | SDRAM address pins |
| mem_size_mb | output | 10 | Memory size in megabytes |

## Verification
The hardest situation to reach is a mode load that is already waiting when initialisation ends. The request must cross the stall during the precharge-all and then the whole settle window before the LMR appears. The stimulus creates this in one register write that sets both the start-init and mode-arm bits. It raises the access request in the next cycle and keeps it up for more than ten thousand cycles. The bench then checks that the LMR comes exactly one cycle after the window, and that no ACTIVE slips out in between.

// File: rtl/sdcfg_pkg.sv
// Shared types and constants for the SDRAM timing-select controller.
// Assumes a single clock domain; bit positions define the register layout.
package sdcfg_pkg;
    typedef enum logic [2:0] {
        CMD_NOP  = 3'd0,
        CMD_ACT  = 3'd1,
        CMD_RD   = 3'd2,
        CMD_WR   = 3'd3,
        CMD_PRE  = 3'd4,
        CMD_PREA = 3'd5,
        CMD_LMR  = 3'd6
    } sd_cmd_e;

    localparam int REG_W = 16;
    localparam int B_CL   = 0;
    localparam int B_RCD  = 1;
    localparam int B_WR   = 2;
    localparam int B_RP   = 3;
    localparam int B_RC   = 4;
    localparam int B_LMR  = 5;
    localparam int B_INIT = 6;
    localparam int B_SZ   = 8;
    localparam int SZ_W   = 3;

    // index of each nanosecond-budget selection inside the packed cycle array
    localparam int IX_RCD = 0;
    localparam int IX_WR  = 1;
    localparam int IX_RP  = 2;
    localparam int IX_RC  = 3;
    localparam int N_SEL  = 4;

    // whole cycles covering ns at period clk_ns, never below one
    function automatic int ns_to_cyc(input int ns, input int clk_ns);
        int c;
        c = (ns + clk_ns - 1) / clk_ns;
        return (c < 1) ? 1 : c;
    endfunction
endpackage

// File: rtl/sdcfg_regs.sv
// Configuration register: timing selections, size code and the two
// self-clearing control bits (start-init, mode-arm).
// Assumes the sequencer pulses init_done / lmr_done for one cycle.
module sdcfg_regs
    import sdcfg_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_we,
    input  logic [REG_W-1:0]   cfg_wdata,
    input  logic               init_done,
    input  logic               lmr_done,
    output logic [REG_W-1:0]   cfg_rdata,
    output logic               cl3,
    output logic [N_SEL-1:0]   slow,
    output logic               init_busy,
    output logic               lmr_arm,
    output logic [9:0]         mem_size_mb
);
    logic [SZ_W-1:0] size_q;
    logic            unused_wbits;

    assign unused_wbits = ^{cfg_wdata[REG_W-1:B_SZ+SZ_W], cfg_wdata[7]};

    // register state: plain fields load on write, control bits set-only
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cl3       <= 1'b0;
            slow      <= '0;
            size_q    <= '0;
            init_busy <= 1'b0;
            lmr_arm   <= 1'b0;
        end else begin
            if (cfg_we) begin
                cl3          <= cfg_wdata[B_CL];
                slow[IX_RCD] <= cfg_wdata[B_RCD];
                slow[IX_WR]  <= cfg_wdata[B_WR];
                slow[IX_RP]  <= cfg_wdata[B_RP];
                slow[IX_RC]  <= cfg_wdata[B_RC];
                size_q       <= cfg_wdata[B_SZ +: SZ_W];
            end
            init_busy <= (init_busy && !init_done) || (cfg_we && cfg_wdata[B_INIT]);
            lmr_arm   <= (lmr_arm && !lmr_done) || (cfg_we && cfg_wdata[B_LMR]);
        end
    end

    // read-back image of the register
    always_comb begin
        cfg_rdata                 = '0;
        cfg_rdata[B_CL]           = cl3;
        cfg_rdata[B_RCD]          = slow[IX_RCD];
        cfg_rdata[B_WR]           = slow[IX_WR];
        cfg_rdata[B_RP]           = slow[IX_RP];
        cfg_rdata[B_RC]           = slow[IX_RC];
        cfg_rdata[B_LMR]          = lmr_arm;
        cfg_rdata[B_INIT]         = init_busy;
        cfg_rdata[B_SZ +: SZ_W]   = size_q;
    end

    // capacity in megabytes from the size code
    assign mem_size_mb = 10'd4 << size_q;
endmodule

// File: rtl/sdcfg_timing.sv
// Turns each one-bit fast/slow selection into a cycle count, fixed at
// elaboration from CLK_NS. Assumes budgets are whole nanoseconds.
module sdcfg_timing
    import sdcfg_pkg::*;
#(
    parameter int CLK_NS = 20,
    parameter int CW     = 8
) (
    input  logic [N_SEL-1:0]          slow,
    output logic [N_SEL-1:0][CW-1:0]  cyc
);
    localparam int FAST_NS [N_SEL] = '{25, 25, 25, 75};
    localparam int SLOW_NS [N_SEL] = '{50, 50, 50, 100};

    // one two-way constant mux per selection
    for (genvar g = 0; g < N_SEL; g++) begin : g_sel
        localparam int FC = ns_to_cyc(FAST_NS[g], CLK_NS);
        localparam int SC = ns_to_cyc(SLOW_NS[g], CLK_NS);
        assign cyc[g] = slow[g] ? CW'(SC) : CW'(FC);
    end
endmodule

// File: rtl/sdcfg_seq.sv
// Command sequencer: precharge-all for init, LMR for an armed access,
// otherwise ACTIVE / column / acknowledge / PRECHARGE. A single wait
// counter with a return state spaces the commands.
// Assumes acc_req is held until acc_ack and dropped in the ack cycle.
module sdcfg_seq
    import sdcfg_pkg::*;
#(
    parameter int AW         = 24,
    parameter int SDA_W      = 13,
    parameter int COL_W      = 9,
    parameter int AP_BIT     = 10,
    parameter int CW         = 8,
    parameter int SETTLE_CYC = 10000
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     acc_req,
    input  logic                     acc_we,
    input  logic [AW-1:0]            acc_addr,
    input  logic                     init_busy,
    input  logic                     lmr_arm,
    input  logic                     cl3,
    input  logic [N_SEL-1:0][CW-1:0] cyc,
    output logic                     acc_ack,
    output logic [2:0]               sd_cmd,
    output logic [SDA_W-1:0]         sd_addr,
    output logic                     init_done,
    output logic                     lmr_done
);
    localparam int SW = $clog2(SETTLE_CYC + 1);

    typedef enum logic [2:0] {S_IDLE, S_PREA, S_ACT, S_COL, S_ACK, S_PRE, S_LMR, S_WAIT} st_e;
    typedef enum logic [1:0] {OP_INIT, OP_RD, OP_WR, OP_LMR} op_e;

    st_e             st, ret_q;
    op_e             op_q;
    logic [CW-1:0]   cnt;
    logic [SW-1:0]   settle;
    logic [AW-1:0]   addr_q;
    logic [CW-1:0]   cl_cyc;
    logic            wait_end;
    logic            unused_abits;

    assign unused_abits = ^addr_q[1:0];
    assign cl_cyc   = cl3 ? CW'(3) : CW'(2);
    assign wait_end = (st == S_WAIT) && (cnt <= CW'(1));

    // state, wait counter, captured access and settle window
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st     <= S_IDLE;
            ret_q  <= S_IDLE;
            op_q   <= OP_RD;
            cnt    <= '0;
            settle <= '0;
            addr_q <= '0;
        end else begin
            if (settle != '0) settle <= settle - SW'(1);
            case (st)
                S_IDLE: begin
                    if (init_busy) begin
                        st   <= S_PREA;
                        op_q <= OP_INIT;
                    end else if (acc_req && lmr_arm) begin
                        if (settle == '0) begin
                            st     <= S_LMR;
                            op_q   <= OP_LMR;
                            addr_q <= acc_addr;
                        end
                    end else if (acc_req) begin
                        st     <= S_ACT;
                        op_q   <= acc_we ? OP_WR : OP_RD;
                        addr_q <= acc_addr;
                    end
                end
                S_PREA: begin cnt <= cyc[IX_RP]  - CW'(1); ret_q <= S_IDLE; st <= S_WAIT; end
                S_ACT:  begin cnt <= cyc[IX_RCD] - CW'(1); ret_q <= S_COL;  st <= S_WAIT; end
                S_COL:  begin cnt <= cl_cyc      - CW'(1); ret_q <= S_ACK;  st <= S_WAIT; end
                S_LMR:  begin cnt <= cyc[IX_RC]  - CW'(1); ret_q <= S_ACK;  st <= S_WAIT; end
                S_PRE:  begin cnt <= cyc[IX_RP]  - CW'(1); ret_q <= S_IDLE; st <= S_WAIT; end
                S_ACK: begin
                    if (op_q == OP_WR) begin
                        cnt   <= cyc[IX_WR] - CW'(1);
                        ret_q <= S_PRE;
                        st    <= S_WAIT;
                    end else if (op_q == OP_RD) begin
                        st <= S_PRE;
                    end else begin
                        st <= S_IDLE;
                    end
                end
                S_WAIT: begin
                    if (wait_end) begin
                        st <= ret_q;
                        if (op_q == OP_INIT) settle <= SW'(SETTLE_CYC);
                    end else begin
                        cnt <= cnt - CW'(1);
                    end
                end
                default: st <= S_IDLE;
            endcase
        end
    end

    // completion pulses back to the register
    assign init_done = wait_end && (op_q == OP_INIT);
    assign lmr_done  = (st == S_LMR);
    assign acc_ack   = (st == S_ACK);

    // command and address pins decoded from the state
    always_comb begin
        sd_cmd  = CMD_NOP;
        sd_addr = '0;
        case (st)
            S_PREA: begin sd_cmd = CMD_PREA; sd_addr[AP_BIT] = 1'b1; end
            S_ACT:  begin sd_cmd = CMD_ACT;  sd_addr = addr_q[COL_W+2 +: SDA_W]; end
            S_COL:  begin
                sd_cmd  = (op_q == OP_WR) ? CMD_WR : CMD_RD;
                sd_addr = SDA_W'(addr_q[2 +: COL_W]);
            end
            S_PRE:  sd_cmd = CMD_PRE;
            S_LMR:  begin sd_cmd = CMD_LMR; sd_addr = addr_q[2 +: SDA_W]; end
            default: ;
        endcase
    end
endmodule

// File: rtl/sdcfg_ctrl.sv
// Top of the SDRAM timing-select controller: register, cycle-count
// selection and command sequencer. Assumes AW >= COL_W + 2 + SDA_W.
module sdcfg_ctrl
    import sdcfg_pkg::*;
#(
    parameter int CLK_NS    = 20,
    parameter int AW        = 24,
    parameter int SDA_W     = 13,
    parameter int COL_W     = 9,
    parameter int AP_BIT    = 10,
    parameter int CW        = 8,
    parameter int SETTLE_NS = 200000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [15:0]      cfg_wdata,
    output logic [15:0]      cfg_rdata,
    input  logic             acc_req,
    input  logic             acc_we,
    input  logic [AW-1:0]    acc_addr,
    output logic             acc_ack,
    output logic [2:0]       sd_cmd,
    output logic [SDA_W-1:0] sd_addr,
    output logic [9:0]       mem_size_mb
);
    localparam int SETTLE_CYC = ns_to_cyc(SETTLE_NS, CLK_NS);

    logic                     cl3, init_busy, lmr_arm, init_done, lmr_done;
    logic [N_SEL-1:0]         slow;
    logic [N_SEL-1:0][CW-1:0] cyc;

    sdcfg_regs regs_i (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .init_done(init_done), .lmr_done(lmr_done), .cfg_rdata(cfg_rdata),
        .cl3(cl3), .slow(slow), .init_busy(init_busy), .lmr_arm(lmr_arm),
        .mem_size_mb(mem_size_mb)
    );

    sdcfg_timing #(.CLK_NS(CLK_NS), .CW(CW)) timing_i (
        .slow(slow), .cyc(cyc)
    );

    sdcfg_seq #(
        .AW(AW), .SDA_W(SDA_W), .COL_W(COL_W), .AP_BIT(AP_BIT),
        .CW(CW), .SETTLE_CYC(SETTLE_CYC)
    ) seq_i (
        .clk(clk), .rst_n(rst_n), .acc_req(acc_req), .acc_we(acc_we),
        .acc_addr(acc_addr), .init_busy(init_busy), .lmr_arm(lmr_arm),
        .cl3(cl3), .cyc(cyc), .acc_ack(acc_ack), .sd_cmd(sd_cmd),
        .sd_addr(sd_addr), .init_done(init_done), .lmr_done(lmr_done)
    );
endmodule

// File: rtl/sdcfg_ctrl_chk.sv
// Protocol checker for sdcfg_ctrl, attached with bind. Tracks the last
// non-NOP command to relate acknowledges and column commands to it.
module sdcfg_ctrl_chk
    import sdcfg_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       acc_ack,
    input logic [2:0] sd_cmd,
    input logic       init_bit,
    input logic       arm_bit,
    input logic       arm_wr
);
    logic [2:0] last_cmd;

    // remembers the most recent command other than NOP
    always_ff @(posedge clk) begin
        if (!rst_n)                last_cmd <= CMD_NOP;
        else if (sd_cmd != CMD_NOP) last_cmd <= sd_cmd;
    end

    AST_ACK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        acc_ack |=> !acc_ack);  // R3
    AST_ACK_AFTER_COLUMN: assert property (@(posedge clk) disable iff (!rst_n)
        acc_ack |-> (last_cmd == CMD_RD || last_cmd == CMD_WR || last_cmd == CMD_LMR));  // R3
    AST_COLUMN_AFTER_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (sd_cmd == CMD_RD || sd_cmd == CMD_WR) |-> last_cmd == CMD_ACT);  // R4
    AST_PRECHARGE_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        (sd_cmd == CMD_PRE || sd_cmd == CMD_PREA) |=> sd_cmd == CMD_NOP);  // R6
    AST_NO_ACTIVE_IN_INIT: assert property (@(posedge clk) disable iff (!rst_n)
        sd_cmd == CMD_ACT |-> !$past(init_bit));  // R7
    AST_PREA_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        sd_cmd == CMD_PREA |-> init_bit);  // R7
    AST_LMR_DISARMS: assert property (@(posedge clk) disable iff (!rst_n)
        sd_cmd == CMD_LMR |=> (!arm_bit || $past(arm_wr)));  // R9
endmodule

bind sdcfg_ctrl sdcfg_ctrl_chk chk_i (
    .clk(clk),
    .rst_n(rst_n),
    .acc_ack(acc_ack),
    .sd_cmd(sd_cmd),
    .init_bit(cfg_rdata[sdcfg_pkg::B_INIT]),
    .arm_bit(cfg_rdata[sdcfg_pkg::B_LMR]),
    .arm_wr(cfg_we && cfg_wdata[sdcfg_pkg::B_LMR])
);

// File: tb/sdcfg_ctrl_tb_top.sv
`timescale 1ns/1ps
module sdcfg_ctrl_tb_top;
    localparam int SETTLE = 200000 / 20;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [15:0] cfg_wdata = '0;
    logic [15:0] cfg_rdata;
    logic        acc_req = 1'b0;
    logic        acc_we = 1'b0;
    logic [23:0] acc_addr = '0;
    logic        acc_ack;
    logic [2:0]  sd_cmd;
    logic [12:0] sd_addr;
    logic [9:0]  mem_size_mb;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;

    // events seen by the watcher
    int t_act1, t_act2, t_col, t_ack1, t_pre1, t_prea, t_lmr, t_clr;
    int n_act, n_ack, n_lmr, row_a, col_a, col_cmd, lmr_a, prea_a;
    bit prev_init;

    // vector fields: timing bits [29:25], write flag [24], address [23:0]
    localparam logic [29:0] VECS [6] = '{
        {5'b00000, 1'b0, 24'h123456},
        {5'b11111, 1'b1, 24'hABCDEC},
        {5'b00101, 1'b1, 24'h0007FC},
        {5'b01010, 1'b0, 24'hFFF800},
        {5'b10011, 1'b0, 24'h5A5A5A},
        {5'b01100, 1'b1, 24'h800004}
    };
    logic [4:0]  vt;
    logic        vw;
    logic [23:0] va;
    int e_cl, e_rcd, e_wr, e_rp, t0;

    sdcfg_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .acc_req(acc_req), .acc_we(acc_we),
        .acc_addr(acc_addr), .acc_ack(acc_ack), .sd_cmd(sd_cmd),
        .sd_addr(sd_addr), .mem_size_mb(mem_size_mb)
    );

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic cfg_write(input logic [15:0] v);
        @(negedge clk);
        cfg_we = 1'b1;
        cfg_wdata = v;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // follows commands until stop_acks acknowledges, then drops the request
    task automatic watch(input int stop_acks, input int max_cyc);
        t_act1 = -1; t_act2 = -1; t_col = -1; t_ack1 = -1; t_pre1 = -1;
        t_prea = -1; t_lmr = -1; t_clr = -1;
        n_act = 0; n_ack = 0; n_lmr = 0; row_a = -1; col_a = -1;
        col_cmd = -1; lmr_a = -1; prea_a = -1;
        prev_init = cfg_rdata[6];
        for (int i = 0; i < max_cyc; i++) begin
            @(negedge clk);
            if (prev_init && !cfg_rdata[6] && t_clr < 0) t_clr = cyc;
            prev_init = cfg_rdata[6];
            case (sd_cmd)
                3'd1: begin
                    if (n_act == 0) begin t_act1 = cyc; row_a = int'(sd_addr); end
                    else if (n_act == 1) t_act2 = cyc;
                    n_act++;
                end
                3'd2, 3'd3: if (t_col < 0) begin
                    t_col = cyc; col_a = int'(sd_addr); col_cmd = int'(sd_cmd);
                end
                3'd4: if (t_pre1 < 0) t_pre1 = cyc;
                3'd5: if (t_prea < 0) begin t_prea = cyc; prea_a = int'(sd_addr); end
                3'd6: begin
                    if (n_lmr == 0) begin t_lmr = cyc; lmr_a = int'(sd_addr); end
                    n_lmr++;
                end
                default: ;
            endcase
            if (acc_ack) begin
                if (n_ack == 0) t_ack1 = cyc;
                n_ack++;
            end
            if (n_ack == stop_acks) begin
                acc_req = 1'b0;
                break;
            end
        end
        repeat (10) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", "register after reset", int'(cfg_rdata), 0);
        check("R1", "command after reset", int'(sd_cmd), 0);
        check("R1", "ack after reset", int'(acc_ack), 0);
        check("R1", "size after reset", int'(mem_size_mb), 4);

        // table of timing selections, each run as two back-to-back accesses
        for (int v = 0; v < 6; v++) begin
            vt = VECS[v][29:25];
            vw = VECS[v][24];
            va = VECS[v][23:0];
            e_cl  = vt[0] ? 3 : 2;
            e_rcd = vt[1] ? 3 : 2;
            e_wr  = vt[2] ? 3 : 2;
            e_rp  = vt[3] ? 3 : 2;
            cfg_write({11'b0, vt});
            check("R2", "timing bits readback", int'(cfg_rdata[4:0]), int'(vt));
            acc_we = vw;
            acc_addr = va;
            acc_req = 1'b1;
            watch(2, 80);
            check("R3", "acks seen", n_ack, 2);
            check("R4", "ACTIVE to column", t_col - t_act1, e_rcd);
            check("R3", "column to ack", t_ack1 - t_col, e_cl);
            check("R5", "ack to PRECHARGE", t_pre1 - t_ack1, vw ? e_wr : 1);
            check("R6", "PRECHARGE to next ACTIVE", t_act2 - t_pre1, e_rp + 1);
            check("R11", "row address", row_a, int'(va[23:11]));
            check("R11", "column address", col_a, int'(va[10:2]));
            check("R11", "column command", col_cmd, vw ? 3 : 2);
        end

        // size code
        cfg_write(16'h0100);
        check("R10", "size code 1", int'(mem_size_mb), 8);
        cfg_write(16'h0500);
        check("R10", "size code 5", int'(mem_size_mb), 128);
        check("R2", "size readback", int'(cfg_rdata[10:8]), 5);
        cfg_write(16'h0700);
        check("R10", "size code 7", int'(mem_size_mb), 512);

        // init with an access waiting
        cfg_write(16'h0040);
        check("R7", "init bit reads 1", int'(cfg_rdata[6]), 1);
        t0 = cyc;
        acc_we = 1'b0;
        acc_addr = 24'h3C0010;
        acc_req = 1'b1;
        watch(1, 80);
        check("R7", "precharge-all timing", t_prea - t0, 1);
        check("R7", "precharge-all address bit 10", (prea_a >> 10) & 1, 1);
        check("R6", "init clears after window", t_clr - t_prea, 2);
        check("R7", "stalled ACTIVE after clear", t_act1 - t_clr, 1);
        check("R7", "access completes", n_ack, 1);

        // init plus armed mode load: settle window then LMR
        cfg_write(16'h0061);
        acc_addr = 24'h0000C8;
        acc_req = 1'b1;
        watch(1, SETTLE + 200);
        check("R8", "LMR after settle window", t_lmr - t_clr, SETTLE + 1);
        check("R9", "no ACTIVE for mode load", n_act, 0);
        check("R9", "mode value CL3 burst 4", lmr_a, 'h032);
        check("R9", "LMR to ack fast", t_ack1 - t_lmr, 4);
        check("R9", "arm bit clears", int'(cfg_rdata[5]), 0);

        // writing 0 to control bits has no effect; slow mode-load gap
        cfg_write(16'h0030);
        cfg_write(16'h0010);
        check("R2", "arm bit kept by write of 0", int'(cfg_rdata[5]), 1);
        check("R2", "init bit not set by write of 0", int'(cfg_rdata[6]), 0);
        acc_addr = 24'h000088;
        acc_req = 1'b1;
        watch(1, 80);
        check("R9", "mode value CL2 burst 4", lmr_a, 'h022);
        check("R9", "LMR to ack slow", t_ack1 - t_lmr, 5);
        acc_addr = 24'h001000;
        acc_req = 1'b1;
        watch(1, 80);
        check("R9", "next access normal ACTIVE", n_act, 1);
        check("R9", "next access not LMR", n_lmr, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule